// File: doc/BRIEF.md
# Polyphase Interpolating Shaping Filter

This block raises the sample rate of a single real baseband stream with a polyphase FIR. Every accepted input sample yields a burst of outputs, one per interpolation phase, in ascending phase order. The output of phase `p` is the sum, over the enabled taps `k`, of coefficient `p + 16*k` multiplied by the sample that is `k` positions back in the input history. The filter gain therefore equals the coefficient sum divided by the interpolation factor.

Coefficients sit in a 256-word store that a simple write port loads. A static mode bit selects how each stored word is read: a 16-bit two's complement value, or a signed 20-bit mantissa with a 4-bit exponent that shifts it right. The wide accumulator is truncated to the 16-bit output format and clamped at plus and minus full scale. The interpolation factor and the tap count are static configuration inputs.

Both stream sides use valid/ready. On the input side `s_ready` is high only when no burst is pending, so a sample is taken only after every phase of the previous one has been emitted. On the output side a word with `m_valid` high is held with unchanged data until `m_ready` is seen high at a clock edge. The producer may hold `s_valid` for as long as it likes, and the consumer may stall for any number of cycles.

Top module: `pif_shaper`

## Requirements
- R1: While `rst_n` is low and right after it is released, `m_valid` is 0 and `s_ready` is 1. Reset clears the sample history and every coefficient word to zero, including during a burst.
- R2: The output of phase `p` equals the sum over enabled taps `k` of coef[p + 16*k] times x[n-k], where x[n] is the newest accepted sample.
- R3: The coefficient of phase `p` and tap `k` is the word at store address `p + 16*k`. Phases run 0..15, taps 0..3, and `cw_addr` spans 0..255.
- R4: After a sample is accepted, exactly `cfg_interp` outputs follow in phase order 0, 1, ... `s_ready` stays low until the last phase of the burst is loaded into the output register.
- R5: While `m_valid` is 1 and `m_ready` is 0, `m_valid` stays 1 and `m_data` stays unchanged.
- R6: With `cfg_float` = 0, the coefficient is `cw_data[15:0]` as signed Q1.15. A write whose `cw_data[15:0]` is 0x8000 is dropped in this mode, and the stored word keeps its old value.
- R7: With `cfg_float` = 1, the coefficient is the signed Q1.19 mantissa `cw_data[23:4]` times 2^-e, where e = `cw_data[3:0]`. In this mode every write, 0x8000 in the low half included, is stored.
- R8: Samples and outputs are signed Q1.15. The output is the exact sum rounded toward minus infinity to 2^-15. A result above 0x7FFF gives 0x7FFF, and one below -1.0 gives 0x8000.
- R9: Only taps 0..`cfg_taps`-1 contribute (1 to 4). The coefficients of the taps above that count have no effect on the output.
- R10: Each accepted sample becomes x[n] and moves every older sample one tap further back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_float | input | 1 | Coefficient format: 0 two's complement, 1 mantissa/exponent |
| cfg_interp | input | 5 | Interpolation factor, 1 to 16 |
| cfg_taps | input | 3 | Taps per phase, 1 to 4 |
| cw_en | input | 1 | Coefficient write strobe |
| cw_addr | input | 8 | Coefficient address, phase + 16*tap |
| cw_data | input | 24 | Coefficient word |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Filter can take a sample |
| s_data | input | 16 | Input sample, signed Q1.15 |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Consumer takes the output word |
| m_data | output | 16 | Output sample, signed Q1.15 |

## Verification
The bench builds the filter with its default parameters: 16 phases, 4 taps, a 256-word store, 16-bit samples and a 20/4 mantissa/exponent split. With these values it can cover the full phase range (factors 1, 4 and 16), every tap count from 1 to 4, both coefficient formats including the largest exponent, and clamping at both ends. A reference model in the bench mirrors the store and the history from the requirements alone. Hand-worked values pin down the address mapping, rejection of 0x8000, rounding toward minus infinity and the disabled taps.

// File: rtl/pif_pkg.sv
package pif_pkg;

  // Coefficient word interpretation selected by the mode bit
  typedef enum logic {
    FMT_FIXED = 1'b0,
    FMT_FLOAT = 1'b1
  } coef_fmt_e;

  // Default field widths of a stored coefficient word
  localparam int PIF_MANT_W  = 20;
  localparam int PIF_EXP_W   = 4;
  localparam int PIF_FIXED_W = 16;

endpackage

// File: rtl/pif_coef_bank.sv
module pif_coef_bank
  import pif_pkg::*;
#(
  parameter int MANT_W     = PIF_MANT_W,
  parameter int EXP_W      = PIF_EXP_W,
  parameter int FIXED_W    = PIF_FIXED_W,
  parameter int MAX_PHASES = 16,
  parameter int MAX_TAPS   = 4,
  parameter int DEPTH      = 256,
  parameter int PH_W       = 5,
  localparam int WORD_W    = MANT_W + EXP_W,
  localparam int ADDR_W    = $clog2(DEPTH),
  localparam int SHR       = (1 << EXP_W) - 1,
  localparam int CI_W      = MANT_W + SHR
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_float,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [WORD_W-1:0]                wr_data,
  input  logic [PH_W-1:0]                  phase,
  output logic [MAX_TAPS-1:0][CI_W-1:0]    coef
);

  localparam int FIX_PAD = CI_W - FIXED_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic              reject;

  // A fixed-format write of the most negative code is refused
  always_comb begin
    reject = (cfg_float == FMT_FIXED) &&
             (wr_data[FIXED_W-1:0] == {1'b1, {(FIXED_W-1){1'b0}}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en && !reject) begin
      mem[wr_addr] <= wr_data;
    end
  end

  // One read port per tap: address = phase + tap * MAX_PHASES
  for (genvar k = 0; k < MAX_TAPS; k++) begin : g_tap
    logic [ADDR_W-1:0]      rd_addr;
    logic [WORD_W-1:0]      word;
    logic signed [CI_W-1:0] flt_full;
    logic signed [CI_W-1:0] flt_val;
    logic signed [CI_W-1:0] fix_val;

    always_comb begin
      rd_addr  = ADDR_W'(k * MAX_PHASES) + ADDR_W'(phase);
      word     = mem[rd_addr];
      fix_val  = $signed({word[FIXED_W-1:0], {FIX_PAD{1'b0}}});
      flt_full = $signed({word[WORD_W-1:EXP_W], {SHR{1'b0}}});
      flt_val  = flt_full >>> word[EXP_W-1:0];
      coef[k]  = (cfg_float == FMT_FLOAT) ? flt_val : fix_val;
    end
  end

  // Checker state: remembers the word that a refused write targeted
  logic              chk_rej;
  logic [ADDR_W-1:0] chk_addr;
  logic [WORD_W-1:0] chk_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_rej  <= 1'b0;
      chk_addr <= '0;
      chk_old  <= '0;
    end else begin
      chk_rej  <= wr_en && (cfg_float == FMT_FIXED) &&
                  (wr_data[FIXED_W-1:0] == {1'b1, {(FIXED_W-1){1'b0}}});
      chk_addr <= wr_addr;
      chk_old  <= mem[wr_addr];
    end
  end

  // R6: a refused write leaves the stored word as it was
  a_r6_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    chk_rej |-> (mem[chk_addr] == chk_old));

endmodule

// File: rtl/pif_history.sv
module pif_history #(
  parameter int DATA_W   = 16,
  parameter int MAX_TAPS = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             push,
  input  logic [DATA_W-1:0]                din,
  output logic [MAX_TAPS-1:0][DATA_W-1:0]  hist
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
    end else if (push) begin
      hist[0] <= din;
      for (int k = 1; k < MAX_TAPS; k++) hist[k] <= hist[k-1];
    end
  end

  // R10: the newest sample lands in slot 0
  a_r10_push_head: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (hist[0] == $past(din)));

  // R10: older samples move one slot back on each push
  for (genvar k = 1; k < MAX_TAPS; k++) begin : g_chk
    a_r10_push_age: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> (hist[k] == $past(hist[k-1])));
  end

endmodule

// File: rtl/pif_mac.sv
module pif_mac #(
  parameter int DATA_W   = 16,
  parameter int MAX_TAPS = 4,
  parameter int CI_W     = 35,
  parameter int GUARD    = 6,
  parameter int TN_W     = 3,
  localparam int CF      = CI_W - 1,
  localparam int P_W     = DATA_W + CI_W,
  localparam int A_W     = P_W + GUARD,
  localparam int SH_W    = A_W - CF
) (
  input  logic [MAX_TAPS-1:0][DATA_W-1:0] hist,
  input  logic [MAX_TAPS-1:0][CI_W-1:0]   coef,
  input  logic [TN_W-1:0]                 cfg_taps,
  output logic [DATA_W-1:0]               y
);

  logic signed [P_W-1:0]  prod [MAX_TAPS];
  logic [MAX_TAPS-1:0]    tap_en;
  logic signed [A_W-1:0]  acc;
  logic [SH_W-1:0]        top;
  logic                   fits;

  for (genvar k = 0; k < MAX_TAPS; k++) begin : g_mul
    always_comb begin
      prod[k]   = $signed(hist[k]) * $signed(coef[k]);
      tap_en[k] = (k == 0) || (k < int'(cfg_taps));
    end
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < MAX_TAPS; k++) begin
      if (tap_en[k]) acc = acc + $signed({{GUARD{prod[k][P_W-1]}}, prod[k]});
    end
    // Drop the fraction bits below 2^-(DATA_W-1): rounds toward minus infinity
    top  = acc[A_W-1:CF];
    fits = (&top[SH_W-1:DATA_W-1]) || !(|top[SH_W-1:DATA_W-1]);
    if (fits)             y = top[DATA_W-1:0];
    else if (top[SH_W-1]) y = {1'b1, {(DATA_W-1){1'b0}}};
    else                  y = {1'b0, {(DATA_W-1){1'b1}}};
  end

endmodule

// File: rtl/pif_shaper.sv
module pif_shaper
  import pif_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int MANT_W     = PIF_MANT_W,
  parameter int EXP_W      = PIF_EXP_W,
  parameter int FIXED_W    = PIF_FIXED_W,
  parameter int MAX_PHASES = 16,
  parameter int MAX_TAPS   = 4,
  parameter int COEF_DEPTH = 256,
  parameter int GUARD      = 6,
  localparam int WORD_W    = MANT_W + EXP_W,
  localparam int ADDR_W    = $clog2(COEF_DEPTH),
  localparam int IP_W      = $clog2(MAX_PHASES + 1),
  localparam int TN_W      = $clog2(MAX_TAPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_float,
  input  logic [IP_W-1:0]   cfg_interp,
  input  logic [TN_W-1:0]   cfg_taps,
  input  logic              cw_en,
  input  logic [ADDR_W-1:0] cw_addr,
  input  logic [WORD_W-1:0] cw_data,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data
);

  localparam int CI_W = MANT_W + (1 << EXP_W) - 1;

  logic                            busy;
  logic [IP_W-1:0]                 phase;
  logic [IP_W-1:0]                 ip_last;
  logic                            accept;
  logic                            emit;
  logic [MAX_TAPS-1:0][DATA_W-1:0] hist;
  logic [MAX_TAPS-1:0][CI_W-1:0]   coef;
  logic [DATA_W-1:0]               mac_y;
  logic                            m_valid_q;
  logic [DATA_W-1:0]               m_data_q;

  // Last phase index, with out-of-range factors pulled into 1..MAX_PHASES
  always_comb begin
    if (cfg_interp == '0)                    ip_last = '0;
    else if (int'(cfg_interp) > MAX_PHASES)  ip_last = IP_W'(MAX_PHASES - 1);
    else                                     ip_last = cfg_interp - 1'b1;
  end

  assign s_ready = !busy;
  assign accept  = s_valid && !busy;
  assign emit    = busy && (!m_valid_q || m_ready);
  assign m_valid = m_valid_q;
  assign m_data  = m_data_q;

  pif_history #(
    .DATA_W   (DATA_W),
    .MAX_TAPS (MAX_TAPS)
  ) u_hist (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (accept),
    .din   (s_data),
    .hist  (hist)
  );

  pif_coef_bank #(
    .MANT_W     (MANT_W),
    .EXP_W      (EXP_W),
    .FIXED_W    (FIXED_W),
    .MAX_PHASES (MAX_PHASES),
    .MAX_TAPS   (MAX_TAPS),
    .DEPTH      (COEF_DEPTH),
    .PH_W       (IP_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_float (cfg_float),
    .wr_en     (cw_en),
    .wr_addr   (cw_addr),
    .wr_data   (cw_data),
    .phase     (phase),
    .coef      (coef)
  );

  pif_mac #(
    .DATA_W   (DATA_W),
    .MAX_TAPS (MAX_TAPS),
    .CI_W     (CI_W),
    .GUARD    (GUARD),
    .TN_W     (TN_W)
  ) u_mac (
    .hist     (hist),
    .coef     (coef),
    .cfg_taps (cfg_taps),
    .y        (mac_y)
  );

  // Burst sequencer: one phase per slot in which the output register is free
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      phase <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      phase <= '0;
    end else if (emit) begin
      if (phase == ip_last) busy  <= 1'b0;
      else                  phase <= phase + 1'b1;
    end
  end

  // Output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid_q <= 1'b0;
      m_data_q  <= '0;
    end else if (emit) begin
      m_valid_q <= 1'b1;
      m_data_q  <= mac_y;
    end else if (m_ready) begin
      m_valid_q <= 1'b0;
    end
  end

  // R5: a stalled output word does not move
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  // R4: a taken sample closes the input until its burst is out
  a_r4_single_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  // R4: the phase index never passes the configured last phase
  a_r4_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (phase <= ip_last));

endmodule

// File: tb/test_pif_shaper.sv
`timescale 1ns/1ps
module test_pif_shaper;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_float = 1'b0;
  logic [4:0]  cfg_interp = 5'd1;
  logic [2:0]  cfg_taps = 3'd1;
  logic        cw_en = 1'b0;
  logic [7:0]  cw_addr = '0;
  logic [23:0] cw_data = '0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [15:0] s_data = '0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [15:0] m_data;

  always #2.5 clk = ~clk;

  pif_shaper i_pif_shaper (
    .clk(clk), .rst_n(rst_n), .cfg_float(cfg_float), .cfg_interp(cfg_interp),
    .cfg_taps(cfg_taps), .cw_en(cw_en), .cw_addr(cw_addr), .cw_data(cw_data),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Reference state built from the requirements
  logic [23:0] sh_mem [256];
  longint      hx [4];
  logic [15:0] got [16];

  localparam logic [15:0] STIM [10] = '{
    16'h1000, 16'h7FFF, 16'h8000, 16'hC000, 16'h0001,
    16'h4000, 16'hFFFF, 16'h2345, 16'h8001, 16'h0000
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic longint cval(input logic [23:0] w);
    longint m;
    if (!cfg_float) return longint'($signed(w[15:0])) * 64'sd524288;
    m = longint'($signed(w[23:4]));
    return m * (longint'(1) << (15 - int'(w[3:0])));
  endfunction

  function automatic logic [15:0] model(input int p);
    longint s = 0;
    for (int k = 0; k < int'(cfg_taps); k++) s += cval(sh_mem[p + 16*k]) * hx[k];
    s = s >>> 34;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s[15:0];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 256; i++) sh_mem[i] = '0;
    for (int k = 0; k < 4; k++) hx[k] = 0;
  endtask

  task automatic wr(input int a, input logic [23:0] d);
    @(negedge clk);
    cw_en = 1'b1; cw_addr = 8'(a); cw_data = d;
    @(negedge clk);
    cw_en = 1'b0;
    if (!(!cfg_float && d[15:0] == 16'h8000)) sh_mem[a] = d;
  endtask

  task automatic clear_coefs();
    for (int i = 0; i < 64; i++) wr(i, 24'h0);
  endtask

  task automatic set_cfg(input int ip, input int tp, input bit fl);
    @(negedge clk);
    cfg_interp = 5'(ip); cfg_taps = 3'(tp); cfg_float = fl;
  endtask

  // Feed one sample, check every phase against the model, optionally stall phase 0
  task automatic send(input logic [15:0] x, input string tag, input int hold);
    int ip = int'(cfg_interp);
    logic [15:0] e;
    @(negedge clk);
    if (hold > 0) m_ready = 1'b0;
    s_valid = 1'b1; s_data = x;
    while (!s_ready) @(negedge clk);
    @(posedge clk);
    for (int k = 3; k > 0; k--) hx[k] = hx[k-1];
    hx[0] = longint'($signed(x));
    @(negedge clk);
    s_valid = 1'b0;
    while (!m_valid) @(negedge clk);
    for (int p = 0; p < ip; p++) begin
      e = model(p);
      got[p] = m_data;
      chk({tag, " R2 phase output"}, m_data, e);
      chk("R4 input closed during burst", {15'd0, s_ready}, {15'd0, (p == ip - 1)});
      if (p == 0 && hold > 0) begin
        for (int h = 0; h < hold; h++) begin
          @(negedge clk);
          chk("R5 stalled word held", {m_valid, m_data[14:0]}, {1'b1, e[14:0]});
          chk("R5 stalled word sign", {15'd0, m_data[15]}, {15'd0, e[15]});
        end
        m_ready = 1'b1;
      end
      if (p < ip - 1) @(negedge clk);
    end
    @(negedge clk);
    chk("R4 no extra output", {15'd0, m_valid}, 16'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 m_valid in reset", {15'd0, m_valid}, 16'd0);
    chk("R1 s_ready in reset", {15'd0, s_ready}, 16'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 m_valid after reset", {15'd0, m_valid}, 16'd0);
    chk("R1 s_ready after reset", {15'd0, s_ready}, 16'd1);

    // Table walk: factor 4, three taps, fixed format, varied coefficients
    set_cfg(4, 3, 1'b0);
    for (int p = 0; p < 16; p++)
      for (int k = 0; k < 4; k++) begin
        int c = (p * 16'h0731 + k * 16'h1357 + 16'h0400) & 16'h7FFF;
        if ((p + k) % 2 == 1) c = -c;
        wr(p + 16*k, {8'h00, 16'(c)});
      end
    foreach (STIM[i]) send(STIM[i], "R10 table", 0);

    // R3: a single word at phase 2, tap 1 (address 18)
    set_cfg(4, 2, 1'b0);
    clear_coefs();
    wr(18, 24'h004000);
    send(16'h2000, "R3 setup", 0);
    chk("R3 phase2 newest sample", got[2], 16'h0000);
    send(16'h0000, "R3", 0);
    chk("R3 phase2 tap1", got[2], 16'h1000);
    chk("R3 phase1 unused", got[1], 16'h0000);

    // R6: 0x8000 refused in fixed mode
    set_cfg(1, 1, 1'b0);
    wr(0, 24'h001234);
    wr(0, 24'h008000);
    send(16'h7FFF, "R6", 0);
    chk("R6 refused write keeps word", got[0], 16'h1233);

    // R7: mantissa/exponent format
    set_cfg(1, 1, 1'b1);
    wr(0, 24'h008000);
    send(16'h7FFF, "R7", 0);
    chk("R7 0x8000 stored in float mode", got[0], 16'h007F);
    wr(0, 24'h400001);
    send(16'h4000, "R7", 0);
    chk("R7 exponent 1", got[0], 16'h1000);
    wr(0, 24'h80000F);
    send(16'h4000, "R8", 0);
    chk("R8 floor of -2^-16", got[0], 16'hFFFF);
    wr(0, 24'h7FFFF0);
    send(16'h8000, "R8", 0);
    chk("R8 floor near -1.0", got[0], 16'h8000);

    // R8: clamping at both ends with four taps
    set_cfg(1, 4, 1'b0);
    for (int k = 0; k < 4; k++) wr(16*k, 24'h007FFF);
    for (int i = 0; i < 4; i++) send(16'h7FFF, "R8 pos", 0);
    chk("R8 clamp high", got[0], 16'h7FFF);
    for (int i = 0; i < 4; i++) send(16'h8000, "R8 neg", 0);
    chk("R8 clamp low", got[0], 16'h8000);

    // R9: tap 2 ignored with two taps, used with three
    set_cfg(1, 2, 1'b0);
    clear_coefs();
    wr(32, 24'h004000);
    for (int i = 0; i < 3; i++) send(16'h4000, "R9", 0);
    chk("R9 tap2 disabled", got[0], 16'h0000);
    set_cfg(1, 3, 1'b0);
    send(16'h0000, "R9", 0);
    chk("R9 tap2 enabled", got[0], 16'h2000);

    // R4: all sixteen phases in order
    set_cfg(16, 1, 1'b0);
    for (int p = 0; p < 16; p++) wr(p, {8'h00, 16'(p * 16'h0100)});
    send(16'h7FFF, "R4", 0);
    chk("R4 phase 5 order", got[5], 16'h04FF);
    chk("R4 phase 15 order", got[15], 16'h0EFF);

    // R5: back-pressure on the first phase
    set_cfg(4, 1, 1'b0);
    send(16'h5555, "R5", 3);

    // R1: reset during a burst, then history and store start from zero
    set_cfg(8, 2, 1'b0);
    @(negedge clk);
    s_valid = 1'b1; s_data = 16'h7000;
    @(negedge clk);
    s_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    chk("R1 m_valid after mid-burst reset", {15'd0, m_valid}, 16'd0);
    chk("R1 s_ready after mid-burst reset", {15'd0, s_ready}, 16'd1);
    rst_n = 1'b1;
    set_cfg(1, 2, 1'b0);
    wr(0, 24'h004000);
    wr(16, 24'h004000);
    send(16'h2000, "R1", 0);
    chk("R1 history cleared", got[0], 16'h1000);

    finish_run();
  end

endmodule